// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits between instruction fetch and a decoder that only understands full-width 32-bit instruction words. Each fetch word carries two 16-bit compressed instructions. A byte-order input decides which of the two halves is the instruction to execute now. The block rewrites that halfword into the equivalent 32-bit instruction. It picks a base opcode from a small table chosen by the compressed format, then moves the register, immediate and offset fields of the halfword into their wide-format positions.

Alongside the word, a 2-bit status tells the execute side how to treat it. The status says the word is ready to issue, or that the halfword is a branch form handled by separate logic, or that the encoding is undefined and must go to the exception handler. The expansion is purely combinational. A parameter can add one register stage on the output.

Top module: `cx_expander`

## Requirements
- R1: With `big_end_i` high, bits 31:16 of the fetch word are the current halfword h. With it low, bits 15:0 are h. The other half never affects the outputs.
- R2: When h[15:11] is 0, 1 or 2 (shift by immediate), the output is 0xE1B00000 with these fields: h[12:11] at 6:5, h[10:6] at 11:7, h[5:3] at 3:0 and h[2:0] at 15:12.
- R3: When h[15:11] is 3, h[10:9] selects 0xE0900000, 0xE0500000, 0xE2900000 or 0xE2500000, in that index order. The fields are h[8:6] at 3:0, h[5:3] at 19:16 and h[2:0] at 15:12.
- R4: When h[15:11] is 4 to 7, h[12:11] selects 0xE3B00000, 0xE3500000, 0xE2900000 or 0xE2500000. h[7:0] goes to 7:0, and h[10:8] goes to both 19:16 and 15:12.
- R5: When h[15:11] is 8 and h[10] is 0, h[9:6] indexes a 16-entry table of base words and operand placements. The general placement puts d=h[2:0] at 19:16 and 15:12, and s=h[5:3] at 3:0. The shift entries (2,3,4,7) put d at 15:12 and 3:0, and s at 11:8. Entry 9 (0xE2700000) puts d at 15:12 and s at 19:16. Entry 13 (0xE0100090) puts d at 19:16 and 11:8, and s at 3:0.
- R6: When h[15:11] is 8 and h[10] is 1, D={h[7],h[2:0]} and S={h[6],h[5:3]}. Operations h[9:6]=1..3, 5..7 and 9..11 map to 0xE0800000, 0xE1500000 and 0xE1A00000, each with D at 19:16 and 15:12 and S at 3:0. Operations 12 and 13 map to 0xE12FFF10 with h[6:3] at 3:0. Operations 0, 4, 8, 14 and 15 are undefined.
- R7: When h[15:11] is 9, the output is 0xE59F0000. When h[15:11] is 18 or 19, the base is 0xE58D0000 for h[11]=0 and 0xE59D0000 for h[11]=1. Both forms put h[10:8] at 15:12 and h[7:0]×4 at 11:0.
- R8: When h[15:11] is 10 or 11, h[9] and h[11:10] select the base word. With h[9]=0 the words are 0xE7800000, 0xE7C00000, 0xE7900000 and 0xE7D00000. With h[9]=1 they are 0xE18000B0, 0xE19000D0, 0xE19000B0 and 0xE19000F0. The fields are h[2:0] at 15:12, h[5:3] at 19:16 and h[8:6] at 3:0.
- R9: When h[15:11] is 12 to 15, h[12:11] selects 0xE5800000, 0xE5900000, 0xE5C00000 or 0xE5D00000, with h[2:0] at 15:12 and h[5:3] at 19:16. The offset h[10:6] goes in unscaled when h[12]=1 and ×4 when h[12]=0. When h[15:11] is 16 or 17, the base is 0xE1C000B0 for h[11]=0 and 0xE1D000B0 for h[11]=1, with the same register fields. The offset h[10:6]×2 is split: its low nibble goes to 3:0 and its high nibble to 11:8.
- R10: When h[15:11] is 20 or 21, the base is 0xE28F0F00 for h[11]=0 and 0xE28D0F00 for h[11]=1, with h[10:8] at 15:12 and h[7:0] unshifted at 7:0. When h[15:8] is 0xB0, the base is 0xE28DDF00 for h[7]=0 and 0xE24DDF00 for h[7]=1, with h[6:0] at 6:0.
- R11: When h[15:11] is 22 or 23 and h[11:8] is 4, 5, 12 or 13, the output is 0xE92D0000, 0xE92D4000, 0xE8BD0000 or 0xE8BD8000 ORed with h[7:0]. Any other h[11:8] is undefined. When h[15:11] is 24 or 25, the output is 0xE8A00000 for h[11]=0 and 0xE8B00000 for h[11]=1, with h[10:8] at 19:16 and h[7:0] at 7:0.
- R12: When h[15:11] is 26 or 27: h[11:8]=15 expands to 0xEF000000 ORed with h[7:0], h[11:8]=14 is undefined, and any other value is branch-handled. Codes 28, 30 and 31 are branch-handled. Code 29 is undefined.
- R13: `status_o` is 0 for decoded, 1 for branch-handled and 2 for undefined, and is never 3. Any status other than decoded forces `insn_o` to zero.
- R14: With REG_OUT=1 the outputs change one clock after the inputs. During reset the outputs read word 0 with status undefined. With REG_OUT=0 the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_word_i | input | FETCH_W | Two packed compressed instructions |
| big_end_i | input | 1 | High: the current instruction is the upper half |
| insn_o | output | 32 | Expanded instruction word |
| status_o | output | 2 | 0 decoded, 1 branch-handled, 2 undefined |

## Verification
The checker watches the output contract on every cycle. Status 3 never appears, a non-decoded status always comes with a zero word, and every decoded word carries the always-execute condition nibble. The trap form must also produce its opcode byte one stage later. The bench has to show what the checker cannot: the exact field relocation of each format, the order of entries in the register-ALU table, and that the non-current halfword has no effect. It does this by sweeping all 65536 halfwords in both byte orders against an arithmetic model. Extra scenarios cover the combinational variant and register latency.

// File: rtl/cx_pkg.sv
package cx_pkg;
  typedef enum logic [1:0] {
    CX_DEC     = 2'b00,
    CX_HANDLED = 2'b01,
    CX_UNDEF   = 2'b10
  } cx_stat_e;

  typedef enum logic [1:0] {
    PL_GEN, PL_SHF, PL_NEG, PL_MUL
  } cx_place_e;

  typedef struct packed {
    logic [31:0] base;
    cx_place_e   place;
  } cx_alu_ent_t;

  // register ALU table, index order is architectural
  function automatic cx_alu_ent_t alu_entry(input logic [3:0] idx);
    case (idx)
      4'h0: return '{32'hE0100000, PL_GEN};
      4'h1: return '{32'hE0300000, PL_GEN};
      4'h2: return '{32'hE1B00010, PL_SHF};
      4'h3: return '{32'hE1B00030, PL_SHF};
      4'h4: return '{32'hE1B00050, PL_SHF};
      4'h5: return '{32'hE0B00000, PL_GEN};
      4'h6: return '{32'hE0D00000, PL_GEN};
      4'h7: return '{32'hE1B00070, PL_SHF};
      4'h8: return '{32'hE1100000, PL_GEN};
      4'h9: return '{32'hE2700000, PL_NEG};
      4'hA: return '{32'hE1500000, PL_GEN};
      4'hB: return '{32'hE1700000, PL_GEN};
      4'hC: return '{32'hE1900000, PL_GEN};
      4'hD: return '{32'hE0100090, PL_MUL};
      4'hE: return '{32'hE1D00000, PL_GEN};
      default: return '{32'hE1F00000, PL_GEN};
    endcase
  endfunction
endpackage

// File: rtl/cx_half_sel.sv
module cx_half_sel #(
  parameter int FETCH_W = 32,
  localparam int HALF_W = FETCH_W / 2
) (
  input  logic [FETCH_W-1:0] fetch_i,
  input  logic               big_end_i,
  output logic [HALF_W-1:0]  cur_o
);
  assign cur_o = big_end_i ? fetch_i[FETCH_W-1:HALF_W] : fetch_i[HALF_W-1:0];
endmodule

// File: rtl/cx_decode.sv
module cx_decode
  import cx_pkg::*;
(
  input  logic [15:0] h_i,
  output logic [31:0] word_o,
  output cx_stat_e    stat_o
);
  logic [4:0]  op;
  logic [3:0]  hd, hs;
  logic [31:0] d12, d16, s0, s16, o0, m12, m16, imm8;
  cx_alu_ent_t ent;

  assign op   = h_i[15:11];
  assign hd   = {h_i[7], h_i[2:0]};
  assign hs   = {h_i[6], h_i[5:3]};
  assign d12  = 32'(h_i[2:0]) << 12;
  assign d16  = 32'(h_i[2:0]) << 16;
  assign s0   = 32'(h_i[5:3]);
  assign s16  = 32'(h_i[5:3]) << 16;
  assign o0   = 32'(h_i[8:6]);
  assign m12  = 32'(h_i[10:8]) << 12;
  assign m16  = 32'(h_i[10:8]) << 16;
  assign imm8 = 32'(h_i[7:0]);
  assign ent  = alu_entry(h_i[9:6]);

  always_comb begin
    word_o = '0;
    stat_o = CX_DEC;
    case (op)
      5'd0, 5'd1, 5'd2:
        word_o = 32'hE1B00000 | (32'(h_i[12:11]) << 5) | (32'(h_i[10:6]) << 7) | s0 | d12;
      5'd3: begin
        case (h_i[10:9])
          2'd0: word_o = 32'hE0900000;
          2'd1: word_o = 32'hE0500000;
          2'd2: word_o = 32'hE2900000;
          default: word_o = 32'hE2500000;
        endcase
        word_o = word_o | o0 | s16 | d12;
      end
      5'd4, 5'd5, 5'd6, 5'd7: begin
        case (h_i[12:11])
          2'd0: word_o = 32'hE3B00000;
          2'd1: word_o = 32'hE3500000;
          2'd2: word_o = 32'hE2900000;
          default: word_o = 32'hE2500000;
        endcase
        word_o = word_o | imm8 | m16 | m12;
      end
      5'd8: begin
        if (!h_i[10]) begin
          case (ent.place)
            PL_GEN:  word_o = ent.base | d16 | d12 | s0;
            PL_SHF:  word_o = ent.base | d12 | 32'(h_i[2:0]) | (32'(h_i[5:3]) << 8);
            PL_NEG:  word_o = ent.base | d12 | s16;
            default: word_o = ent.base | d16 | (32'(h_i[2:0]) << 8) | s0;
          endcase
        end else begin
          case (h_i[9:6])
            4'd1, 4'd2, 4'd3:
              word_o = 32'hE0800000 | (32'(hd) << 16) | (32'(hd) << 12) | 32'(hs);
            4'd5, 4'd6, 4'd7:
              word_o = 32'hE1500000 | (32'(hd) << 16) | (32'(hd) << 12) | 32'(hs);
            4'd9, 4'd10, 4'd11:
              word_o = 32'hE1A00000 | (32'(hd) << 16) | (32'(hd) << 12) | 32'(hs);
            4'd12, 4'd13:
              word_o = 32'hE12FFF10 | 32'(h_i[6:3]);
            default: stat_o = CX_UNDEF;
          endcase
        end
      end
      5'd9:
        word_o = 32'hE59F0000 | m12 | (imm8 << 2);
      5'd10, 5'd11: begin
        case ({h_i[9], h_i[11:10]})
          3'd0: word_o = 32'hE7800000;
          3'd1: word_o = 32'hE7C00000;
          3'd2: word_o = 32'hE7900000;
          3'd3: word_o = 32'hE7D00000;
          3'd4: word_o = 32'hE18000B0;
          3'd5: word_o = 32'hE19000D0;
          3'd6: word_o = 32'hE19000B0;
          default: word_o = 32'hE19000F0;
        endcase
        word_o = word_o | d12 | s16 | o0;
      end
      5'd12, 5'd13, 5'd14, 5'd15: begin
        case (h_i[12:11])
          2'd0: word_o = 32'hE5800000;
          2'd1: word_o = 32'hE5900000;
          2'd2: word_o = 32'hE5C00000;
          default: word_o = 32'hE5D00000;
        endcase
        word_o = word_o | d12 | s16 |
                 (h_i[12] ? 32'(h_i[10:6]) : (32'(h_i[10:6]) << 2));
      end
      5'd16, 5'd17:
        word_o = (h_i[11] ? 32'hE1D000B0 : 32'hE1C000B0) | d12 | s16 |
                 (o0 << 1) | (32'(h_i[10:9]) << 8);
      5'd18, 5'd19:
        word_o = (h_i[11] ? 32'hE59D0000 : 32'hE58D0000) | m12 | (imm8 << 2);
      5'd20, 5'd21:
        word_o = (h_i[11] ? 32'hE28D0F00 : 32'hE28F0F00) | m12 | imm8;
      5'd22, 5'd23: begin
        case (h_i[11:8])
          4'h0: word_o = (h_i[7] ? 32'hE24DDF00 : 32'hE28DDF00) | 32'(h_i[6:0]);
          4'h4: word_o = 32'hE92D0000 | imm8;
          4'h5: word_o = 32'hE92D4000 | imm8;
          4'hC: word_o = 32'hE8BD0000 | imm8;
          4'hD: word_o = 32'hE8BD8000 | imm8;
          default: stat_o = CX_UNDEF;
        endcase
      end
      5'd24, 5'd25:
        word_o = (h_i[11] ? 32'hE8B00000 : 32'hE8A00000) | m16 | imm8;
      5'd26, 5'd27: begin
        if (h_i[11:8] == 4'hF)      word_o = 32'hEF000000 | imm8;
        else if (h_i[11:8] == 4'hE) stat_o = CX_UNDEF;
        else                        stat_o = CX_HANDLED;
      end
      5'd29:   stat_o = CX_UNDEF;
      default: stat_o = CX_HANDLED;
    endcase
  end
endmodule

// File: rtl/cx_out_stage.sv
module cx_out_stage #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  input  logic [1:0]   stat_i,
  output logic [W-1:0] word_o,
  output logic [1:0]   stat_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_o <= '0;
        stat_o <= 2'b10;
      end else begin
        word_o <= word_i;
        stat_o <= stat_i;
      end
    end
  end else begin : g_comb
    assign word_o = word_i;
    assign stat_o = stat_i;
  end
endmodule

// File: rtl/cx_expander.sv
module cx_expander
  import cx_pkg::*;
#(
  parameter int FETCH_W = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int HALF_W = FETCH_W / 2,
  localparam int OUT_W  = 2 * HALF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FETCH_W-1:0] fetch_word_i,
  input  logic               big_end_i,
  output logic [OUT_W-1:0]   insn_o,
  output logic [1:0]         status_o
);
  logic [HALF_W-1:0] cur;
  logic [31:0]       dec_word;
  cx_stat_e          dec_stat;

  cx_half_sel #(.FETCH_W(FETCH_W)) u_sel (
    .fetch_i(fetch_word_i), .big_end_i(big_end_i), .cur_o(cur)
  );

  cx_decode u_dec (.h_i(cur), .word_o(dec_word), .stat_o(dec_stat));

  cx_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .word_i(dec_word), .stat_i(dec_stat),
    .word_o(insn_o), .stat_o(status_o)
  );
endmodule

// File: rtl/cx_expander_chk.sv
module cx_expander_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] fetch_word_i,
  input logic        big_end_i,
  input logic [31:0] insn_o,
  input logic [1:0]  status_o
);
  logic [15:0] cur;
  assign cur = big_end_i ? fetch_word_i[31:16] : fetch_word_i[15:0];

  // R13
  stat_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'b11);
  // R13
  quiet_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 2'b00) |-> (insn_o == 32'h0));
  // R13
  always_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'b00) |-> (insn_o[31:28] == 4'hE));

  if (REG_OUT) begin : g_reg
    // R12
    trap_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cur[15:8] == 8'hDF) |=> (status_o == 2'b00 && insn_o[31:24] == 8'hEF));
  end else begin : g_comb
    // R12
    trap_comb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cur[15:8] == 8'hDF) |-> (status_o == 2'b00 && insn_o[31:24] == 8'hEF));
  end
endmodule

bind cx_expander cx_expander_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fetch_word_i(fetch_word_i),
  .big_end_i(big_end_i), .insn_o(insn_o), .status_o(status_o)
);

// File: tb/cx_expander_test.sv
module cx_expander_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_r = '0, fetch_c = '0;
  logic        big_r = 1'b0, big_c = 1'b0;
  logic [31:0] insn_r, insn_c;
  logic [1:0]  stat_r, stat_c;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cx_expander #(.REG_OUT(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_word_i(fetch_r), .big_end_i(big_r),
    .insn_o(insn_r), .status_o(stat_r)
  );
  cx_expander #(.REG_OUT(1'b0)) uut_comb (
    .clk_i(clk), .rst_ni(rst_n), .fetch_word_i(fetch_c), .big_end_i(big_c),
    .insn_o(insn_c), .status_o(stat_c)
  );

  // arithmetic model: returns {status, word}
  function automatic logic [33:0] model(input logic [15:0] h);
    logic [31:0] w = 0;
    logic [1:0]  s = 2'd0;
    int unsigned d = h & 7, sr = (h >> 3) & 7, m = (h >> 8) & 7;
    int unsigned k = (h >> 6) & 15, i8 = h & 255;
    int unsigned c = h >> 11;
    logic [31:0] alu[16] = '{32'hE0100000, 32'hE0300000, 32'hE1B00010, 32'hE1B00030,
                             32'hE1B00050, 32'hE0B00000, 32'hE0D00000, 32'hE1B00070,
                             32'hE1100000, 32'hE2700000, 32'hE1500000, 32'hE1700000,
                             32'hE1900000, 32'hE0100090, 32'hE1D00000, 32'hE1F00000};
    logic [31:0] f3[4] = '{32'hE0900000, 32'hE0500000, 32'hE2900000, 32'hE2500000};
    logic [31:0] f4[4] = '{32'hE3B00000, 32'hE3500000, 32'hE2900000, 32'hE2500000};
    logic [31:0] f8[8] = '{32'hE7800000, 32'hE7C00000, 32'hE7900000, 32'hE7D00000,
                           32'hE18000B0, 32'hE19000D0, 32'hE19000B0, 32'hE19000F0};
    logic [31:0] f9[4] = '{32'hE5800000, 32'hE5900000, 32'hE5C00000, 32'hE5D00000};
    int unsigned sel2 = (h >> 11) & 3, b11 = (h >> 11) & 1, sub = (h >> 8) & 15;
    if (c <= 2)
      w = 32'hE1B00000 + (((h >> 11) & 3) * 32) + (((h >> 6) & 31) * 128) + sr + d * 4096;
    else if (c == 3)
      w = f3[(h >> 9) & 3] + ((h >> 6) & 7) + sr * 65536 + d * 4096;
    else if (c <= 7)
      w = f4[sel2] + i8 + m * 65536 + m * 4096;
    else if (c == 8 && !h[10]) begin
      if (k == 2 || k == 3 || k == 4 || k == 7) w = alu[k] + d * 4096 + d + sr * 256;
      else if (k == 9)  w = alu[k] + d * 4096 + sr * 65536;
      else if (k == 13) w = alu[k] + d * 65536 + d * 256 + sr;
      else              w = alu[k] + d * 65536 + d * 4096 + sr;
    end else if (c == 8) begin
      int unsigned hd = d + 8 * h[7], hs = sr + 8 * h[6];
      if (k >= 1 && k <= 3)       w = 32'hE0800000 + hd * 65536 + hd * 4096 + hs;
      else if (k >= 5 && k <= 7)  w = 32'hE1500000 + hd * 65536 + hd * 4096 + hs;
      else if (k >= 9 && k <= 11) w = 32'hE1A00000 + hd * 65536 + hd * 4096 + hs;
      else if (k == 12 || k == 13) w = 32'hE12FFF10 + ((h >> 3) & 15);
      else s = 2'd2;
    end else if (c == 9)
      w = 32'hE59F0000 + m * 4096 + i8 * 4;
    else if (c <= 11)
      w = f8[h[9] * 4 + ((h >> 10) & 3)] + d * 4096 + sr * 65536 + ((h >> 6) & 7);
    else if (c <= 15)
      w = f9[sel2] + d * 4096 + sr * 65536 + ((h >> 6) & 31) * (h[12] ? 1 : 4);
    else if (c <= 17) begin
      int unsigned off = ((h >> 6) & 31) * 2;
      w = (b11 ? 32'hE1D000B0 : 32'hE1C000B0) + d * 4096 + sr * 65536 + (off & 15) + (off >> 4) * 256;
    end else if (c <= 19)
      w = (b11 ? 32'hE59D0000 : 32'hE58D0000) + m * 4096 + i8 * 4;
    else if (c <= 21)
      w = (b11 ? 32'hE28D0F00 : 32'hE28F0F00) + m * 4096 + i8;
    else if (c <= 23) begin
      if (sub == 0)       w = (h[7] ? 32'hE24DDF00 : 32'hE28DDF00) + (h & 127);
      else if (sub == 4)  w = 32'hE92D0000 + i8;
      else if (sub == 5)  w = 32'hE92D4000 + i8;
      else if (sub == 12) w = 32'hE8BD0000 + i8;
      else if (sub == 13) w = 32'hE8BD8000 + i8;
      else s = 2'd2;
    end else if (c <= 25)
      w = (b11 ? 32'hE8B00000 : 32'hE8A00000) + m * 65536 + i8;
    else if (c <= 27) begin
      if (sub == 15)      w = 32'hEF000000 + i8;
      else if (sub == 14) s = 2'd2;
      else                s = 2'd1;
    end else if (c == 29) s = 2'd2;
    else s = 2'd1;
    return {s, w};
  endfunction

  function automatic string req_of(input logic [15:0] h);
    int unsigned c = h >> 11;
    if (c <= 2) return "R2";
    if (c == 3) return "R3";
    if (c <= 7) return "R4";
    if (c == 8) return h[10] ? "R6" : "R5";
    if (c == 9 || c == 18 || c == 19) return "R7";
    if (c <= 11) return "R8";
    if (c <= 17) return "R9";
    if (c <= 21) return "R10";
    if (c <= 23) return (((h >> 8) & 15) == 0) ? "R10" : "R11";
    if (c <= 25) return "R11";
    return "R12";
  endfunction

  task automatic check(input string req, input logic [31:0] aw, input logic [1:0] as,
                       input logic [31:0] ew, input logic [1:0] es);
    n_chk++;
    if (aw !== ew || as !== es) begin
      n_fail++;
      $display("FAIL %s: actual word=%08h stat=%0d expected word=%08h stat=%0d",
               req, aw, as, ew, es);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(195000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [33:0] e;
    // R14 reset values
    repeat (3) @(negedge clk);
    check("R14", insn_r, stat_r, 32'h0, 2'd2);
    rst_n = 1'b1;

    // R1 selection with distinct halves on the combinational variant
    fetch_c = {16'hDF12, 16'h2A05}; big_c = 1'b1; #1;
    check("R1", insn_c, stat_c, 32'hEF000012, 2'd0);
    big_c = 1'b0; #1;
    check("R1", insn_c, stat_c, 32'hE3522005, 2'd0);
    // hand values for R11, R6, R12, R13
    fetch_c = {16'h0, 16'hB5F0}; #1; check("R11", insn_c, stat_c, 32'hE92D40F0, 2'd0);
    fetch_c = {16'h0, 16'hBD01}; #1; check("R11", insn_c, stat_c, 32'hE8BD8001, 2'd0);
    fetch_c = {16'h0, 16'h4770}; #1; check("R6", insn_c, stat_c, 32'hE12FFF1E, 2'd0);
    fetch_c = {16'h0, 16'h4600}; #1; check("R13", insn_c, stat_c, 32'h0, 2'd2);
    fetch_c = {16'h0, 16'hE000}; #1; check("R12", insn_c, stat_c, 32'h0, 2'd1);

    // R14 latency: output holds until the next edge
    @(negedge clk); fetch_r = {16'h0, 16'hDF33}; big_r = 1'b0;
    @(posedge clk); #1;
    check("R14", insn_r, stat_r, 32'hEF000033, 2'd0);
    @(negedge clk); fetch_r = {16'h0, 16'hE000};
    #1 check("R14", insn_r, stat_r, 32'hEF000033, 2'd0);
    @(posedge clk); #1;
    check("R14", insn_r, stat_r, 32'h0, 2'd1);

    // exhaustive sweep, both byte orders, other half inverted (R1)
    for (int b = 0; b < 2; b++) begin
      for (int v = 0; v < 65536; v++) begin
        logic [15:0] h = v[15:0];
        @(negedge clk);
        big_r   = (b == 1);
        fetch_r = (b == 1) ? {h, ~h} : {~h, h};
        @(posedge clk); #1;
        e = model(h);
        check((b == 1) ? {"R1/", req_of(h)} : req_of(h), insn_r, stat_r, e[31:0], e[33:32]);
      end
    end
    finish_run();
  end
endmodule